// File: doc/BRIEF.md
# Page Translation Cache

This block holds the most recent virtual-page to physical-frame mappings in a small, fully associative array. A lookup presents a virtual page number and a read/write flag. Every valid entry compares its tag against that page number in the same cycle. One cycle later the block returns either a hit, with the frame number, protection bits and global flag, or a miss. A miss tells the external table walker to fetch the mapping. The walker then installs its result through the fill channel. When a write finds an entry whose dirty flag is clear, the block reports a miss, so the walker can mark the page dirty in memory and reinstall the entry with the flag set.

Three maintenance commands arrive on a plain command port: drop one page, drop all non-global entries on a context switch, and drop everything. Lookups and fills are valid/ready channels. The lookup channel stalls (ready low) in any cycle where a fill is offered. The fill channel stalls in any cycle where a command is present. The response has no back-pressure: it is valid for exactly one cycle and must be taken then.

Top module: `xlat_cache`

## Requirements
- R1: After reset the array holds no valid entry, rsp_valid is low, and both lk_ready and fill_ready are high while no fill or command is offered.
- R2: A lookup accepted on a clock edge produces rsp_valid on the next cycle. On a hit, that response carries the installed rsp_pfn, rsp_prot and rsp_global. In a cycle after which no lookup was accepted, rsp_valid is low.
- R3: A lookup whose page number matches no valid entry returns rsp_valid high with rsp_hit low.
- R4: A write lookup (lk_write=1) that matches an entry installed with fill_dirty=0 returns rsp_hit low. The same entry still hits for reads. Once it is installed again with fill_dirty=1, write lookups hit.
- R5: Command code 2'b01 removes only the entry whose tag equals cmd_vpn. Other entries keep hitting.
- R6: Command code 2'b10 removes every entry not installed with fill_global=1. Global entries keep hitting.
- R7: Command code 2'b11 removes every entry and returns the round-robin replacement pointer to slot 0. Code 2'b00 does nothing.
- R8: When a command removes the entry that a lookup accepted in the same cycle would match, that lookup returns rsp_hit low.
- R9: Installing a page number that is already present overwrites that entry in place. Later lookups return the new fields, and no second copy ever occupies a slot.
- R10: A new page goes into the lowest-numbered invalid slot. When every slot is valid, it replaces the slot under a round-robin pointer, and the pointer then advances by one. Filling a free slot leaves the pointer where it is.
- R11: fill_ready is low whenever cmd_valid is high, and an offered fill is not installed in that cycle. lk_ready is low whenever fill_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request offered |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_vpn | input | VPN_W | Page number to translate |
| lk_write | input | 1 | Lookup is for a write |
| rsp_valid | output | 1 | Lookup result present (one cycle) |
| rsp_hit | output | 1 | Translation usable; low means walk needed |
| rsp_pfn | output | PFN_W | Frame number on hit |
| rsp_prot | output | PROT_W | Protection bits on hit |
| rsp_global | output | 1 | Entry survives context flush |
| fill_valid | input | 1 | Walker result offered |
| fill_ready | output | 1 | Fill can be accepted |
| fill_vpn | input | VPN_W | Page number of new mapping |
| fill_pfn | input | PFN_W | Frame number of new mapping |
| fill_prot | input | PROT_W | Protection bits of new mapping |
| fill_global | input | 1 | Mark entry global |
| fill_dirty | input | 1 | Page already marked dirty |
| cmd_valid | input | 1 | Maintenance command present |
| cmd_op | input | 2 | 01 page drop, 10 context flush, 11 flush all |
| cmd_vpn | input | VPN_W | Page for the single-page drop |

## Verification
A lookup and a maintenance command can land on the same clock edge, and the command must win. The bench offers a lookup of a resident page together with a drop of that same page. It judges the response one cycle later, which must be a miss, and then confirms with a plain lookup that the entry is really gone. A fill offered together with a command is the other collision. That case is judged by fill_ready being low and by a later lookup of the offered page still missing.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam logic [1:0] CMD_NONE = 2'b00;
  localparam logic [1:0] CMD_PAGE = 2'b01;
  localparam logic [1:0] CMD_CTX  = 2'b10;
  localparam logic [1:0] CMD_ALL  = 2'b11;
endpackage

// File: rtl/xc_match.sv
module xc_match #(
  parameter int N  = 16,
  parameter int VW = 20
) (
  input  logic [VW-1:0] tags [N],
  input  logic [N-1:0]  live,
  input  logic [VW-1:0] key,
  output logic [N-1:0]  hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = live[i] && (tags[i] == key);
  end
endmodule

// File: rtl/xc_victim.sv
module xc_victim #(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  live,
  input  logic [IW-1:0] rr_ptr,
  output logic [IW-1:0] slot,
  output logic          took_free
);
  logic [IW-1:0] free_idx;
  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!live[i]) free_idx = IW'(i);
    end
  end
  assign took_free = ~&live;
  assign slot      = took_free ? free_idx : rr_ptr;
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int PROT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic              lk_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic [PROT_W-1:0] rsp_prot,
  output logic              rsp_global,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PROT_W-1:0] fill_prot,
  input  logic              fill_global,
  input  logic              fill_dirty,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [VPN_W-1:0]  cmd_vpn
);
  import xc_pkg::*;
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0]  tag_q  [ENTRIES];
  logic [PFN_W-1:0]  pfn_q  [ENTRIES];
  logic [PROT_W-1:0] prot_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, glob_q, dirty_q;
  logic [IW-1:0]     rr_q;

  // Handshakes: commands outrank fills, fills outrank lookups.
  assign fill_ready = !cmd_valid;
  assign lk_ready   = !fill_valid;
  logic lk_fire, fill_fire;
  assign lk_fire   = lk_valid && lk_ready;
  assign fill_fire = fill_valid && fill_ready;

  // Command decode into a kill mask applied before lookup compare.
  logic [ENTRIES-1:0] cmd_hit_vec, kill;
  xc_match #(.N(ENTRIES), .VW(VPN_W)) u_cmd_match (
    .tags(tag_q), .live(valid_q), .key(cmd_vpn), .hit(cmd_hit_vec)
  );
  always_comb begin
    kill = '0;
    if (cmd_valid) begin
      case (cmd_op)
        CMD_PAGE: kill = cmd_hit_vec;
        CMD_CTX:  kill = ~glob_q;
        CMD_ALL:  kill = '1;
        default:  kill = '0;
      endcase
    end
  end

  // Lookup compare against surviving entries.
  logic [ENTRIES-1:0] lk_hit_vec;
  xc_match #(.N(ENTRIES), .VW(VPN_W)) u_lk_match (
    .tags(tag_q), .live(valid_q & ~kill), .key(lk_vpn), .hit(lk_hit_vec)
  );
  logic [PFN_W-1:0]  sel_pfn;
  logic [PROT_W-1:0] sel_prot;
  logic              sel_glob, sel_dirty;
  always_comb begin
    sel_pfn = '0; sel_prot = '0; sel_glob = 1'b0; sel_dirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hit_vec[i]) begin
        sel_pfn   |= pfn_q[i];
        sel_prot  |= prot_q[i];
        sel_glob  |= glob_q[i];
        sel_dirty |= dirty_q[i];
      end
    end
  end
  logic lk_ok;
  assign lk_ok = (|lk_hit_vec) && (!lk_write || sel_dirty);

  // Fill target: existing copy first, else free slot, else round robin.
  logic [ENTRIES-1:0] fill_hit_vec;
  xc_match #(.N(ENTRIES), .VW(VPN_W)) u_fill_match (
    .tags(tag_q), .live(valid_q), .key(fill_vpn), .hit(fill_hit_vec)
  );
  logic [IW-1:0] dup_idx, vic_idx, tgt_idx;
  logic          took_free, is_dup;
  always_comb begin
    dup_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_hit_vec[i]) dup_idx = IW'(i);
    end
  end
  xc_victim #(.N(ENTRIES)) u_victim (
    .live(valid_q), .rr_ptr(rr_q), .slot(vic_idx), .took_free(took_free)
  );
  assign is_dup  = |fill_hit_vec;
  assign tgt_idx = is_dup ? dup_idx : vic_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= valid_q & ~kill;
      if (fill_fire) valid_q[tgt_idx] <= 1'b1;
      if (cmd_valid && cmd_op == CMD_ALL) begin
        rr_q <= '0;
      end else if (fill_fire && !is_dup && !took_free) begin
        rr_q <= (rr_q == IW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_fire) begin
      tag_q[tgt_idx]   <= fill_vpn;
      pfn_q[tgt_idx]   <= fill_pfn;
      prot_q[tgt_idx]  <= fill_prot;
      glob_q[tgt_idx]  <= fill_global;
      dirty_q[tgt_idx] <= fill_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_pfn    <= '0;
      rsp_prot   <= '0;
      rsp_global <= 1'b0;
    end else begin
      rsp_valid <= lk_fire;
      if (lk_fire) begin
        rsp_hit    <= lk_ok;
        rsp_pfn    <= sel_pfn;
        rsp_prot   <= sel_prot;
        rsp_global <= sel_glob;
      end
    end
  end
endmodule

// File: rtl/xc_chk.sv
module xc_chk #(
  parameter int N  = 16,
  parameter int VW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_valid,
  input logic          lk_ready,
  input logic [VW-1:0] lk_vpn,
  input logic          fill_valid,
  input logic          fill_ready,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic [VW-1:0] cmd_vpn,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic [N-1:0]  lk_hit_vec,
  input logic [N-1:0]  valid_q,
  input logic [N-1:0]  glob_q
);
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_valid && lk_ready) |=> !rsp_valid);
  a_r11_fill_stall: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !fill_ready);
  a_r11_lookup_stall: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !lk_ready);
  a_r9_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec));
  a_r7_flush_all_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b11) |=> (valid_q == '0));
  a_r6_ctx_keeps_global: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b10) |=> ((valid_q & ~glob_q) == '0));
  a_r8_drop_beats_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && cmd_valid && cmd_op == 2'b01 && lk_vpn == cmd_vpn)
      |=> (rsp_valid && !rsp_hit));
endmodule

bind xlat_cache xc_chk #(.N(ENTRIES), .VW(VPN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .lk_vpn(lk_vpn), .fill_valid(fill_valid), .fill_ready(fill_ready),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_vpn(cmd_vpn),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .lk_hit_vec(lk_hit_vec),
  .valid_q(valid_q), .glob_q(glob_q)
);

// File: tb/xlat_cache_bench.sv
`timescale 1ns/1ps
module xlat_cache_bench;
  localparam int VW = 20, PW = 20, RW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, lk_write = 0, fill_valid = 0, fill_global = 0, fill_dirty = 0, cmd_valid = 0;
  logic [VW-1:0] lk_vpn = '0, fill_vpn = '0, cmd_vpn = '0;
  logic [PW-1:0] fill_pfn = '0;
  logic [RW-1:0] fill_prot = '0;
  logic [1:0] cmd_op = 2'b00;
  logic lk_ready, fill_ready, rsp_valid, rsp_hit, rsp_global;
  logic [PW-1:0] rsp_pfn;
  logic [RW-1:0] rsp_prot;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xlat_cache u_xlat_cache (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_vpn(lk_vpn), .lk_write(lk_write), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_pfn(rsp_pfn), .rsp_prot(rsp_prot), .rsp_global(rsp_global),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_prot(fill_prot), .fill_global(fill_global),
    .fill_dirty(fill_dirty), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_vpn(cmd_vpn)
  );

  typedef struct packed {
    logic          is_fill;
    logic [VW-1:0] vpn;
    logic [PW-1:0] pfn;
    logic [RW-1:0] prot;
    logic          glob;
    logic          dw;      // dirty for fill, write for lookup
    logic          exp_hit;
  } vec_t;

  localparam vec_t TBL [11] = '{
    '{1'b0, 20'h00010, 20'h0,     2'b00, 1'b0, 1'b0, 1'b0}, // R1 empty miss
    '{1'b1, 20'h00010, 20'h0ABCD, 2'b11, 1'b0, 1'b0, 1'b0},
    '{1'b0, 20'h00010, 20'h0ABCD, 2'b11, 1'b0, 1'b0, 1'b1}, // R2 read hit
    '{1'b0, 20'h00010, 20'h0,     2'b00, 1'b0, 1'b1, 1'b0}, // R4 clean write misses
    '{1'b1, 20'h00010, 20'h0ABCD, 2'b11, 1'b0, 1'b1, 1'b0},
    '{1'b0, 20'h00010, 20'h0ABCD, 2'b11, 1'b0, 1'b1, 1'b1}, // R4 dirty write hits
    '{1'b1, 20'h00020, 20'h12345, 2'b01, 1'b1, 1'b1, 1'b0},
    '{1'b0, 20'h00020, 20'h12345, 2'b01, 1'b1, 1'b0, 1'b1}, // R2 global entry
    '{1'b0, 20'h00030, 20'h0,     2'b00, 1'b0, 1'b0, 1'b0}, // R3 miss
    '{1'b1, 20'h00010, 20'h55555, 2'b10, 1'b0, 1'b1, 1'b0},
    '{1'b0, 20'h00010, 20'h55555, 2'b10, 1'b0, 1'b0, 1'b1}  // R9 overwrite
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_fill(input logic [VW-1:0] v, input logic [PW-1:0] p,
                         input logic [RW-1:0] pr, input logic g, input logic d);
    fill_valid = 1; fill_vpn = v; fill_pfn = p; fill_prot = pr; fill_global = g; fill_dirty = d;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [VW-1:0] v);
    cmd_valid = 1; cmd_op = op; cmd_vpn = v;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 2'b00;
  endtask

  // Lookup, optionally with a command in the same cycle; result sampled next negedge.
  task automatic do_look(input logic [VW-1:0] v, input logic w, input bit with_cmd,
                         input logic [1:0] op, input logic [VW-1:0] cv);
    lk_valid = 1; lk_vpn = v; lk_write = w;
    if (with_cmd) begin cmd_valid = 1; cmd_op = op; cmd_vpn = cv; end
    @(negedge clk);
    lk_valid = 0; lk_write = 0; cmd_valid = 0; cmd_op = 2'b00;
  endtask

  task automatic expect_hit(input logic [VW-1:0] v, input logic exp, input string req);
    do_look(v, 1'b0, 1'b0, 2'b00, '0);
    chk(rsp_valid && rsp_hit == exp, req, "hit", {30'd0, rsp_valid, rsp_hit}, {30'd0, 1'b1, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!rsp_valid, "R1", "rsp_valid", 32'(rsp_valid), 0);
    chk(lk_ready && fill_ready, "R1", "ready", {30'd0, lk_ready, fill_ready}, 3);

    foreach (TBL[i]) begin
      if (TBL[i].is_fill) begin
        do_fill(TBL[i].vpn, TBL[i].pfn, TBL[i].prot, TBL[i].glob, TBL[i].dw);
      end else begin
        do_look(TBL[i].vpn, TBL[i].dw, 1'b0, 2'b00, '0);
        chk(rsp_valid && rsp_hit == TBL[i].exp_hit, "R2/R3/R4", $sformatf("vec%0d hit", i),
            32'(rsp_hit), 32'(TBL[i].exp_hit));
        if (TBL[i].exp_hit) begin
          chk(rsp_pfn == TBL[i].pfn && rsp_prot == TBL[i].prot && rsp_global == TBL[i].glob,
              "R2/R9", $sformatf("vec%0d fields", i), 32'(rsp_pfn), 32'(TBL[i].pfn));
        end
      end
    end
    // R2: no response without lookup
    @(negedge clk);
    chk(!rsp_valid, "R2", "idle rsp_valid", 32'(rsp_valid), 0);

    // R5 single page drop
    do_cmd(2'b01, 20'h00010);
    expect_hit(20'h00010, 1'b0, "R5");
    expect_hit(20'h00020, 1'b1, "R5");

    // R6 context flush keeps global; R7 code 00 does nothing
    do_fill(20'h00040, 20'h00444, 2'b01, 1'b0, 1'b1);
    do_cmd(2'b00, 20'h00040);
    expect_hit(20'h00040, 1'b1, "R7");
    do_cmd(2'b10, '0);
    expect_hit(20'h00020, 1'b1, "R6");
    expect_hit(20'h00040, 1'b0, "R6");

    // R8 drop in same cycle as lookup
    do_fill(20'h00040, 20'h00444, 2'b01, 1'b0, 1'b1);
    do_look(20'h00040, 1'b0, 1'b1, 2'b01, 20'h00040);
    chk(rsp_valid && !rsp_hit, "R8", "same-cycle drop", 32'(rsp_hit), 0);
    expect_hit(20'h00040, 1'b0, "R8");

    // R11 fill offered with a command is stalled and not installed
    fill_valid = 1; fill_vpn = 20'h00888; fill_pfn = 20'h8; fill_prot = 0; fill_global = 0; fill_dirty = 1;
    cmd_valid = 1; cmd_op = 2'b01; cmd_vpn = 20'h00777;
    #1;
    chk(!fill_ready, "R11", "fill_ready", 32'(fill_ready), 0);
    chk(!lk_ready, "R11", "lk_ready", 32'(lk_ready), 0);
    @(negedge clk);
    fill_valid = 0; cmd_valid = 0; cmd_op = 2'b00;
    expect_hit(20'h00888, 1'b0, "R11");

    // R7 flush all
    do_cmd(2'b11, '0);
    expect_hit(20'h00020, 1'b0, "R7");

    // R10 replacement order
    for (int k = 0; k < 16; k++) do_fill(20'h00100 + VW'(k), 20'h00A00 + PW'(k), 2'b00, 1'b0, 1'b1);
    do_fill(20'h00200, 20'h00B00, 2'b00, 1'b0, 1'b1);
    do_fill(20'h00201, 20'h00B01, 2'b00, 1'b0, 1'b1);
    expect_hit(20'h00100, 1'b0, "R10");
    expect_hit(20'h00101, 1'b0, "R10");
    expect_hit(20'h00102, 1'b1, "R10");
    expect_hit(20'h00200, 1'b1, "R10");
    do_cmd(2'b01, 20'h00105);
    do_fill(20'h00300, 20'h00C00, 2'b00, 1'b0, 1'b1);
    do_fill(20'h00301, 20'h00C01, 2'b00, 1'b0, 1'b1);
    expect_hit(20'h00300, 1'b1, "R10");
    expect_hit(20'h00102, 1'b0, "R10");
    expect_hit(20'h00103, 1'b1, "R10");

    // R9 duplicate install never takes a second slot
    do_cmd(2'b11, '0);
    do_fill(20'h00500, 20'h00D00, 2'b00, 1'b0, 1'b1);
    do_fill(20'h00500, 20'h00D01, 2'b00, 1'b0, 1'b1);
    for (int k = 1; k < 16; k++) do_fill(20'h00500 + VW'(k), 20'h00D00 + PW'(k), 2'b00, 1'b0, 1'b1);
    do_fill(20'h00600, 20'h00E00, 2'b00, 1'b0, 1'b1);
    expect_hit(20'h00500, 1'b0, "R9");
    expect_hit(20'h0050F, 1'b1, "R9");
    expect_hit(20'h00501, 1'b1, "R9");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule